// File: doc/BRIEF.md
# Basic Interval Timer with Watchdog Reset Request

The block runs an 8-bit basic counter and an 8-bit watchdog count from one shared tick. The tick comes from a free-running prescaler on the master clock. A control field selects a power-of-two division, 2^(DIV_MAX_LOG2 - sel), with a default of 2^(13 - sel), which gives divide by 8192, 4096, 2048 or 1024. The basic counter runs freely. Each time it rolls over, the block emits a one-cycle interrupt pulse.

The watchdog count is held in the control register itself. While the watchdog is enabled, the count advances on the same ticks as the basic counter. Software restarts the watchdog by writing the register with a zero count. If the count reaches all ones while enabled, the block raises a reset request. The request stays high until the block's own reset is applied. Driving the reset of the rest of the system is left to logic outside this block.

The control port and the count port are plain register ports: one write strobe and two always-valid read buses. No stream data crosses the block edge, so there is no handshake and no back-pressure.

Top module: `basic_tick_watchdog`

## Requirements
- R1: A tick occurs once every 2^(DIV_MAX_LOG2 - sel) clock cycles. sel is control bits 3:2. The prescaler starts from zero at reset, so the n-th clock edge after reset carries a tick exactly when n is a multiple of that period. DIV_MAX_LOG2 must exceed 3.
- R2: The basic counter on `cnt_rdata` increases by exactly one on every tick and stays unchanged on all other edges.
- R3: On a tick at count 0xFF, the counter becomes 0. `bt_irq` is then high for exactly the one cycle that follows that edge.
- R4: Control bit 16 enables the watchdog. While it is 0, the watchdog count in bits 15:8 keeps its written value.
- R5: While enabled, the watchdog count in bits 15:8 increases by one per tick. It stays at 0xFF once it gets there.
- R6: `wdt_rst_req` rises on the edge that follows a cycle in which the watchdog is enabled with a count of 0xFF. It then stays high until `rst_n` is applied, even if the watchdog is later disabled.
- R7: A write loads bits 16, 15:8 and 3:2 from `ctrl_wdata`. If a tick falls on the same edge, the written count wins. The write leaves the basic counter untouched. All other control bits read as 0. Writing a count of zero restarts the watchdog.
- R8: Reset clears the control register, the basic counter and the prescaler, and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_en | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 17 | Control write data: bit 16 enable, 15:8 watchdog count, 3:2 divider select |
| ctrl_rdata | output | 17 | Control register read-back |
| cnt_rdata | output | 8 | Basic counter value |
| bt_irq | output | 1 | One-cycle pulse after each counter rollover |
| wdt_rst_req | output | 1 | Sticky watchdog reset request |

## Verification
On every cycle, the assertions check the following:
- the counter moves only by single steps;
- the interrupt is a single-cycle pulse that appears only right after a 0xFF-to-0 rollover;
- the watchdog count holds while disabled or saturated, and otherwise moves by at most one step between writes;
- the reset request rises only from an enabled, saturated count, and never falls without reset.

Only the bench scenarios can show that ticks land on the exact edges set by each divider setting, including after a mid-run change of divider. The same holds for the exact cycle on which the request rises and for the effect of a restart.

// File: rtl/bt_wdt_pkg.sv
package bt_wdt_pkg;
  // Control register layout: divider select, watchdog count, watchdog enable.
  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 2;
  localparam int WDT_LSB = 8;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int DIV_MAX_LOG2 = 13,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [DIV_MAX_LOG2-1:0] presc_q;
  logic [DIV_MAX_LOG2-1:0] mask;

  // Only the low (DIV_MAX_LOG2 - sel) bits take part in the tick decode.
  always_comb begin
    for (int i = 0; i < DIV_MAX_LOG2; i++) begin
      mask[i] = (i < (DIV_MAX_LOG2 - int'(sel)));
    end
  end

  assign tick = &(presc_q | ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_q + 1'b1;
  end
endmodule

// File: rtl/bt_base_counter.sv
module bt_base_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             at_top;

  assign at_top = (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tick && at_top;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/bt_wdt_ctrl.sv
module bt_wdt_ctrl #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_wdt_en,
  input  logic [CNT_W-1:0] wr_wdt_cnt,
  input  logic             tick,
  output logic [SEL_W-1:0] sel,
  output logic             wdt_en,
  output logic [CNT_W-1:0] wdt_cnt,
  output logic             rst_req
);
  logic [SEL_W-1:0] sel_q;
  logic             en_q;
  logic [CNT_W-1:0] wdt_q;
  logic             req_q;
  logic             expired;

  assign expired = en_q && (wdt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      wdt_q <= '0;
    end else if (wr_en) begin
      sel_q <= wr_sel;
      en_q  <= wr_wdt_en;
      wdt_q <= wr_wdt_cnt;
    end else if (tick && en_q && !expired) begin
      wdt_q <= wdt_q + 1'b1;
    end
  end

  // Sticky request: only the block reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_q <= 1'b0;
    else if (expired) req_q <= 1'b1;
  end

  assign sel     = sel_q;
  assign wdt_en  = en_q;
  assign wdt_cnt = wdt_q;
  assign rst_req = req_q;
endmodule

// File: rtl/basic_tick_watchdog.sv
module basic_tick_watchdog #(
  parameter int DIV_MAX_LOG2 = 13,
  parameter int CNT_W        = 8
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             ctrl_wr_en,
  input  logic [bt_wdt_pkg::WDT_LSB+CNT_W:0]               ctrl_wdata,
  output logic [bt_wdt_pkg::WDT_LSB+CNT_W:0]               ctrl_rdata,
  output logic [CNT_W-1:0]                                 cnt_rdata,
  output logic                                             bt_irq,
  output logic                                             wdt_rst_req
);
  import bt_wdt_pkg::*;

  localparam int EN_BIT = WDT_LSB + CNT_W;
  localparam int CTRL_W = EN_BIT + 1;

  logic             tick;
  logic [SEL_W-1:0] sel;
  logic             wdt_en;
  logic [CNT_W-1:0] wdt_cnt;
  logic             unused_wdata;

  assign unused_wdata = ^{ctrl_wdata[SEL_LSB-1:0], ctrl_wdata[WDT_LSB-1:SEL_LSB+SEL_W]};

  bt_prescaler #(.DIV_MAX_LOG2(DIV_MAX_LOG2), .SEL_W(SEL_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel),
    .tick (tick)
  );

  bt_base_counter #(.CNT_W(CNT_W)) u_base (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .cnt  (cnt_rdata),
    .irq  (bt_irq)
  );

  bt_wdt_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr_en),
    .wr_sel    (ctrl_wdata[SEL_LSB +: SEL_W]),
    .wr_wdt_en (ctrl_wdata[EN_BIT]),
    .wr_wdt_cnt(ctrl_wdata[WDT_LSB +: CNT_W]),
    .tick      (tick),
    .sel       (sel),
    .wdt_en    (wdt_en),
    .wdt_cnt   (wdt_cnt),
    .rst_req   (wdt_rst_req)
  );

  always_comb begin
    ctrl_rdata                     = '0;
    ctrl_rdata[SEL_LSB +: SEL_W]   = sel;
    ctrl_rdata[WDT_LSB +: CNT_W]   = wdt_cnt;
    ctrl_rdata[EN_BIT]             = wdt_en;
  end
endmodule

// File: rtl/bt_wdt_checker.sv
module bt_wdt_checker #(
  parameter int CNT_W = 8
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                ctrl_wr_en,
  input logic [bt_wdt_pkg::WDT_LSB+CNT_W:0]  ctrl_rdata,
  input logic [CNT_W-1:0]                    cnt_rdata,
  input logic                                bt_irq,
  input logic                                wdt_rst_req
);
  localparam int LSB = bt_wdt_pkg::WDT_LSB;
  localparam int EN  = LSB + CNT_W;

  logic [CNT_W-1:0] wdt;
  logic [CNT_W-1:0] wdt_q, cnt_q;
  logic             en_q, wr_q, req_q;

  assign wdt = ctrl_rdata[LSB +: CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_q <= '0; cnt_q <= '0; en_q <= 1'b0; wr_q <= 1'b0; req_q <= 1'b0;
    end else begin
      wdt_q <= wdt; cnt_q <= cnt_rdata; en_q <= ctrl_rdata[EN];
      wr_q <= ctrl_wr_en; req_q <= wdt_rst_req;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rdata != cnt_q) |-> (cnt_rdata == cnt_q + 1'b1)); // R2
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bt_irq |=> !bt_irq); // R3
  AST_IRQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    bt_irq |-> (cnt_rdata == '0 && cnt_q == '1)); // R3
  AST_WDT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_q && !en_q) |-> (wdt == wdt_q)); // R4
  AST_WDT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_q && wdt != wdt_q) |-> (wdt == wdt_q + 1'b1)); // R5
  AST_WDT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_q && wdt_q == '1) |-> (wdt == '1)); // R5
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_req && !req_q) |-> (wdt_q == '1 && en_q)); // R6
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> wdt_rst_req); // R6
endmodule

bind basic_tick_watchdog bt_wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr_en (ctrl_wr_en),
  .ctrl_rdata (ctrl_rdata),
  .cnt_rdata  (cnt_rdata),
  .bt_irq     (bt_irq),
  .wdt_rst_req(wdt_rst_req)
);

// File: tb/tb_basic_tick_watchdog.sv
`timescale 1ns/1ps
module tb_basic_tick_watchdog;
  localparam int DIVL = 5;  // tick periods 32, 16, 8, 4 for sel 0..3

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr_en = 1'b0;
  logic [16:0] ctrl_wdata = '0;
  logic [16:0] ctrl_rdata;
  logic [7:0]  cnt_rdata;
  logic        bt_irq;
  logic        wdt_rst_req;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_seen = 0;

  always #2.5 clk = ~clk;

  basic_tick_watchdog #(.DIV_MAX_LOG2(DIVL), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .cnt_rdata(cnt_rdata), .bt_irq(bt_irq),
    .wdt_rst_req(wdt_rst_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_seen <= 0;
    else if (bt_irq) irq_seen <= irq_seen + 1;
  end

  typedef struct packed {
    logic [1:0]  sel;
    logic        en;
    logic [7:0]  init;
    logic [15:0] edges;
    logic [7:0]  cnt;
    logic [7:0]  wdt;
    logic        rst;
    logic [7:0]  irqs;
  } vec_t;

  // Edges counted from reset release; the write lands on edge 1.
  localparam vec_t VECS [7] = '{
    '{2'd0, 1'b0, 8'h10, 16'd100,  8'd3,  8'h10, 1'b0, 8'd0},  // R1 R4
    '{2'd3, 1'b1, 8'h00, 16'd40,   8'd10, 8'd10, 1'b0, 8'd0},  // R1 R5
    '{2'd3, 1'b0, 8'h05, 16'd1030, 8'd1,  8'h05, 1'b0, 8'd1},  // R3 wrap
    '{2'd2, 1'b1, 8'hF0, 16'd120,  8'd15, 8'hFF, 1'b0, 8'd0},  // R6 not yet
    '{2'd2, 1'b1, 8'hF0, 16'd121,  8'd15, 8'hFF, 1'b1, 8'd0},  // R6 rises
    '{2'd1, 1'b1, 8'hFE, 16'd200,  8'd12, 8'hFF, 1'b1, 8'd0},  // R5 saturate
    '{2'd2, 1'b1, 8'h00, 16'd64,   8'd8,  8'd8,  1'b0, 8'd0}   // R2
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ctrl_wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_ctrl(input logic [1:0] sel, input logic en, input logic [7:0] wdt);
    ctrl_wdata = {en, wdt, 4'b0, sel, 2'b0};
    ctrl_wr_en = 1'b1;
    @(negedge clk);
    ctrl_wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R8 reset state
    do_reset();
    check("R8 ctrl", int'(ctrl_rdata), 0);
    check("R8 cnt", int'(cnt_rdata), 0);
    check("R8 irq", int'(bt_irq), 0);
    check("R8 rst_req", int'(wdt_rst_req), 0);

    foreach (VECS[i]) begin
      do_reset();
      write_ctrl(VECS[i].sel, VECS[i].en, VECS[i].init);
      run(int'(VECS[i].edges) - 1);
      check("R2 cnt", int'(cnt_rdata), int'(VECS[i].cnt));
      check("R5 wdt", int'(ctrl_rdata[15:8]), int'(VECS[i].wdt));
      check("R6 rst_req", int'(wdt_rst_req), int'(VECS[i].rst));
      check("R3 irq count", irq_seen, int'(VECS[i].irqs));
    end

    // R7 field layout: other bits read zero; R6 request one edge later
    do_reset();
    ctrl_wdata = 17'h1FFFF;
    ctrl_wr_en = 1'b1;
    @(negedge clk);
    ctrl_wr_en = 1'b0;
    check("R7 readback", int'(ctrl_rdata), 'h1FF0C);
    check("R6 not before next edge", int'(wdt_rst_req), 0);
    run(1);
    check("R6 raised", int'(wdt_rst_req), 1);
    run(300);
    check("R6 held", int'(wdt_rst_req), 1);
    write_ctrl(2'd0, 1'b0, 8'h00);
    run(5);
    check("R6 held after disable", int'(wdt_rst_req), 1);
    do_reset();
    check("R8 clears request", int'(wdt_rst_req), 0);

    // R7 restart: write clears the count, basic counter untouched
    do_reset();
    write_ctrl(2'd3, 1'b1, 8'h00);
    run(39);
    check("R5 before restart", int'(ctrl_rdata[15:8]), 10);
    write_ctrl(2'd3, 1'b1, 8'h00);
    check("R7 restart wdt", int'(ctrl_rdata[15:8]), 0);
    check("R7 cnt untouched", int'(cnt_rdata), 10);

    // R1 divider change mid-run
    do_reset();
    write_ctrl(2'd0, 1'b0, 8'h00);
    run(63);
    check("R1 period 32", int'(cnt_rdata), 2);
    write_ctrl(2'd3, 1'b0, 8'h00);
    run(12);
    check("R1 period 4 after change", int'(cnt_rdata), 5);

    finish_run();
  end
endmodule